// File: doc/BRIEF.md
# Base-Integer Hint Encoding Classifier

This block is purely combinational. It takes a 32-bit instruction word from the 64-bit base integer set and reports whether the word occupies a hint code point. Hint code points are encodings that look like ordinary computational instructions, but their operand constraints make them architecturally inert. These constraints are usually a destination of x0, plus exact source or fence-field conditions.

When the word is a hint, the block reports its class. The class is one of:
- a named standard hint, which is one of four non-temporal locality levels or the spin-wait pause;
- space reserved for future standard hints;
- space designated for custom hints.

A separate flag marks the reserved encodings of the word-immediate shifts, where shift-amount bit 5 is set.

A pipeline front end uses these outputs as advice, for example to drop or steer inert operations early. The block does no full decode and raises no exceptions.

Top module: `hint_classifier`

## Requirements
- R1: The class output `hint_class_o` is 0 for a non-hint, 1 for reserved-standard, 2 for custom, 3 for non-temporal, and 4 for pause. A computational word whose destination (bits 11:7) is not x0 is class 0, and so is any word whose major opcode (bits 6:0) is not covered below.
- R2: Destination x0 gives class 1 for these words: load-upper (opcode 0110111), add-upper-to-pc (0010111), and the immediate and/or/xor (opcode 0010011 with funct3 111, 110, 100). It also gives class 1 for the word-immediate add (opcode 0011011 with funct3 000).
- R3: Immediate add (opcode 0010011, funct3 000) with destination x0 is class 1. The only exception is a source of x0 with an all-zero immediate (bits 31:20), which is the plain no-op and is class 0.
- R4: Register add (opcode 0110011, funct3 000, funct7 0000000) with destination x0 and source 1 x0 is class 3 when source 2 (bits 24:20) is x2, x3, x4 or x5. In that case `ntl_sel_o` is the source 2 register number minus 2.
- R5: Every other register add with destination x0 is class 1. Sweeping both sources gives 4 non-temporal points and 1020 reserved points, of which 28 have source 1 equal to x0.
- R6: Destination x0 gives class 1 for the following words, and only with the funct7 values shown:
  - on opcode 0110011: sub and arithmetic right shift (funct7 0100000); and, or, xor, left shift and logical right shift (funct7 0000000);
  - on opcode 0111011: the word add, left shift and logical right shift (funct7 0000000); the word sub and arithmetic right shift (funct7 0100000).
  Any other funct7 is class 0.
- R7: Destination x0 gives class 2 for these words:
  - set-less-than and its unsigned form, both immediate (opcode 0010011, funct3 010 and 011) and register (opcode 0110011, funct3 010 and 011);
  - the immediate shifts (funct3 001 and 101) with valid upper bits;
  - the word-immediate shifts (opcode 0011011) whose bits 31:25 are 0000000 or 0100000.
- R8: A fence word (opcode 0001111, funct3 000) is class 4 under one exact condition: destination x0, source x0, fm (bits 31:28) equal to 0, predecessor set (bits 27:24) equal to 0001 (write only), and successor set (bits 23:20) equal to 0.
- R9: A fence word with fm 0 and an empty predecessor or an empty successor set is class 1 in two cases: exactly one of destination and source is x0, or both are x0 and the pause pattern does not match. Any other fence word is class 0.
- R10: `rsvd_enc_o` is 1 for a word-immediate shift (opcode 0011011, funct3 001 or 101) whose bits 31:26 are valid and whose bit 25 is 1, whatever the destination. Such a word is class 0.
- R11: `ntl_sel_o` is 0 whenever the class is not 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word to classify |
| hint_class_o | output | 3 | Hint class code (see R1) |
| ntl_sel_o | output | 2 | Non-temporal level, valid when class is 3 |
| rsvd_enc_o | output | 1 | Reserved word-shift encoding flag |

## Verification
The hardest points to reach are the single pause code point and the 28 reserved register-add points. Each lies in a narrow corner of a wide field space, so directed vectors alone cannot show that nothing nearby is misclassified. The bench sweeps the full source-register space of destination-x0 adds and the full predecessor/successor space of fences, with every x0 pairing of destination and source. It then compares the number of points in each class against the expected code-point totals. A vector table covers the remaining per-opcode cases.

// File: rtl/hint_pkg.sv
package hint_pkg;

  typedef enum logic [2:0] {
    HC_NONE   = 3'd0,
    HC_RSVD   = 3'd1,
    HC_CUSTOM = 3'd2,
    HC_NTL    = 3'd3,
    HC_PAUSE  = 3'd4
  } hint_class_e;

  localparam logic [6:0] OPC_OP_IMM   = 7'b0010011;
  localparam logic [6:0] OPC_OP_IMM32 = 7'b0011011;
  localparam logic [6:0] OPC_OP       = 7'b0110011;
  localparam logic [6:0] OPC_OP32     = 7'b0111011;
  localparam logic [6:0] OPC_LUI      = 7'b0110111;
  localparam logic [6:0] OPC_AUIPC    = 7'b0010111;
  localparam logic [6:0] OPC_MISC_MEM = 7'b0001111;

  localparam logic [6:0] F7_BASE = 7'b0000000;
  localparam logic [6:0] F7_ALT  = 7'b0100000;
  localparam logic [5:0] F6_BASE = 6'b000000;
  localparam logic [5:0] F6_ALT  = 6'b010000;

  typedef struct packed {
    logic [6:0] f7;
    logic [4:0] rs2;
    logic [4:0] rs1;
    logic [2:0] f3;
    logic [4:0] rd;
    logic [6:0] opc;
  } rword_t;

  typedef struct packed {
    logic [3:0] fm;
    logic [3:0] pred;
    logic [3:0] succ;
  } fence_ord_t;

  function automatic fence_ord_t fence_fields(input rword_t w);
    fence_ord_t f;
    f = fence_ord_t'({w.f7, w.rs2});
    return f;
  endfunction

  function automatic logic [11:0] imm_field(input rword_t w);
    return {w.f7, w.rs2};
  endfunction

  // Shift upper bits legal for a right-shift immediate: logical or arithmetic.
  function automatic logic right_shift_f6_ok(input logic [5:0] f6);
    return (f6 == F6_BASE) || (f6 == F6_ALT);
  endfunction

endpackage

// File: rtl/hint_alu_class.sv
module hint_alu_class
  import hint_pkg::*;
#(
  parameter int NTL_BASE  = 2,
  parameter int NTL_COUNT = 4,
  localparam int SEL_W    = (NTL_COUNT > 1) ? $clog2(NTL_COUNT) : 1
) (
  input  rword_t              w_i,
  output hint_class_e         cls_o,
  output logic [SEL_W-1:0]    ntl_sel_o,
  output logic                ntl_hit_o
);

  localparam logic [4:0] NTL_LO = 5'(NTL_BASE);
  localparam logic [4:0] NTL_HI = 5'(NTL_BASE + NTL_COUNT - 1);

  logic        rd_zero;
  logic        rs1_zero;
  logic        ntl_window;
  logic        f7_base;
  logic        f7_alt;
  hint_class_e raw_cls;
  hint_class_e add_cls;

  assign rd_zero    = (w_i.rd == 5'd0);
  assign rs1_zero   = (w_i.rs1 == 5'd0);
  assign ntl_window = (w_i.rs2 >= NTL_LO) && (w_i.rs2 <= NTL_HI);
  assign f7_base    = (w_i.f7 == F7_BASE);
  assign f7_alt     = (w_i.f7 == F7_ALT);

  // Register add with x0 destination: non-temporal window or reserved.
  always_comb begin
    if (rs1_zero && ntl_window) add_cls = HC_NTL;
    else                        add_cls = HC_RSVD;
  end

  always_comb begin
    raw_cls = HC_NONE;
    unique case (w_i.opc)
      OPC_LUI, OPC_AUIPC: raw_cls = HC_RSVD;
      OPC_OP_IMM: begin
        unique case (w_i.f3)
          3'b000: raw_cls = (!rs1_zero || imm_field(w_i) != 12'd0) ? HC_RSVD : HC_NONE;
          3'b010, 3'b011: raw_cls = HC_CUSTOM;
          3'b100, 3'b110, 3'b111: raw_cls = HC_RSVD;
          3'b001: raw_cls = (w_i.f7[6:1] == F6_BASE) ? HC_CUSTOM : HC_NONE;
          3'b101: raw_cls = right_shift_f6_ok(w_i.f7[6:1]) ? HC_CUSTOM : HC_NONE;
          default: raw_cls = HC_NONE;
        endcase
      end
      OPC_OP_IMM32: begin
        unique case (w_i.f3)
          3'b000: raw_cls = HC_RSVD;
          3'b001: raw_cls = f7_base ? HC_CUSTOM : HC_NONE;
          3'b101: raw_cls = (f7_base || f7_alt) ? HC_CUSTOM : HC_NONE;
          default: raw_cls = HC_NONE;
        endcase
      end
      OPC_OP: begin
        if (f7_base) begin
          unique case (w_i.f3)
            3'b000: raw_cls = add_cls;
            3'b010, 3'b011: raw_cls = HC_CUSTOM;
            default: raw_cls = HC_RSVD;
          endcase
        end else if (f7_alt && (w_i.f3 == 3'b000 || w_i.f3 == 3'b101)) begin
          raw_cls = HC_RSVD;
        end
      end
      OPC_OP32: begin
        if (f7_base && (w_i.f3 == 3'b000 || w_i.f3 == 3'b001 || w_i.f3 == 3'b101))
          raw_cls = HC_RSVD;
        else if (f7_alt && (w_i.f3 == 3'b000 || w_i.f3 == 3'b101))
          raw_cls = HC_RSVD;
      end
      default: raw_cls = HC_NONE;
    endcase
  end

  assign cls_o     = rd_zero ? raw_cls : HC_NONE;
  assign ntl_hit_o = (cls_o == HC_NTL);
  assign ntl_sel_o = ntl_hit_o ? SEL_W'(w_i.rs2 - NTL_LO) : '0;

  always_comb begin
    // R4: a non-temporal hit needs x0 destination, x0 source 1 and the add opcode
    p_ntl_operands_r4: assert (!ntl_hit_o ||
      (rd_zero && rs1_zero && w_i.opc == OPC_OP && w_i.f3 == 3'b000))
      else $error("non-temporal hit with wrong operands");
    // R7: custom space always has a zero destination
    p_custom_rd0_r7: assert (cls_o != HC_CUSTOM || w_i.rd == 5'd0)
      else $error("custom class with nonzero destination");
  end

endmodule

// File: rtl/hint_fence_class.sv
module hint_fence_class
  import hint_pkg::*;
(
  input  rword_t      w_i,
  output hint_class_e cls_o,
  output logic        pause_hit_o
);

  localparam logic [3:0] ORD_W_ONLY = 4'b0001;

  fence_ord_t ord;
  logic       is_fence;
  logic       one_side_empty;
  logic       rd_zero;
  logic       rs1_zero;
  logic       pause_pat;

  assign ord            = fence_fields(w_i);
  assign is_fence       = (w_i.opc == OPC_MISC_MEM) && (w_i.f3 == 3'b000) && (ord.fm == 4'd0);
  assign one_side_empty = (ord.pred == 4'd0) || (ord.succ == 4'd0);
  assign rd_zero        = (w_i.rd == 5'd0);
  assign rs1_zero       = (w_i.rs1 == 5'd0);
  assign pause_pat      = (ord.pred == ORD_W_ONLY) && (ord.succ == 4'd0);

  always_comb begin
    cls_o = HC_NONE;
    if (is_fence && one_side_empty) begin
      if (rd_zero && rs1_zero)      cls_o = pause_pat ? HC_PAUSE : HC_RSVD;
      else if (rd_zero ^ rs1_zero)  cls_o = HC_RSVD;
    end
  end

  assign pause_hit_o = (cls_o == HC_PAUSE);

  always_comb begin
    // R8: pause only from the exact write-only predecessor, empty successor pattern
    p_pause_exact_r8: assert (!pause_hit_o ||
      (w_i[31:20] == 12'h010 && w_i[19:7] == 13'd0 && w_i.opc == OPC_MISC_MEM))
      else $error("pause raised for a non-pause word");
    // R9: both registers nonzero never yields a fence hint
    p_fence_regs_r9: assert (cls_o == HC_NONE || rd_zero || rs1_zero)
      else $error("fence hint with both registers nonzero");
  end

endmodule

// File: rtl/hint_shamt_guard.sv
module hint_shamt_guard
  import hint_pkg::*;
(
  input  rword_t w_i,
  output logic   rsvd_o
);

  logic shift_left;
  logic shift_right;
  logic upper_ok;

  assign shift_left  = (w_i.opc == OPC_OP_IMM32) && (w_i.f3 == 3'b001);
  assign shift_right = (w_i.opc == OPC_OP_IMM32) && (w_i.f3 == 3'b101);
  assign upper_ok    = (shift_left && w_i.f7[6:1] == F6_BASE) ||
                       (shift_right && right_shift_f6_ok(w_i.f7[6:1]));
  assign rsvd_o      = upper_ok && w_i.f7[0];

endmodule

// File: rtl/hint_classifier.sv
module hint_classifier
  import hint_pkg::*;
#(
  parameter int NTL_BASE  = 2,
  parameter int NTL_COUNT = 4,
  localparam int SEL_W    = (NTL_COUNT > 1) ? $clog2(NTL_COUNT) : 1
) (
  input  logic [31:0]      instr_i,
  output logic [2:0]       hint_class_o,
  output logic [SEL_W-1:0] ntl_sel_o,
  output logic             rsvd_enc_o
);

  rword_t           word;
  hint_class_e      alu_cls;
  hint_class_e      fence_cls;
  hint_class_e      final_cls;
  logic [SEL_W-1:0] alu_sel;
  logic             ntl_hit;
  logic             pause_hit;
  logic             shamt_rsvd;

  assign word = rword_t'(instr_i);

  hint_alu_class #(
    .NTL_BASE  (NTL_BASE),
    .NTL_COUNT (NTL_COUNT)
  ) u_alu (
    .w_i       (word),
    .cls_o     (alu_cls),
    .ntl_sel_o (alu_sel),
    .ntl_hit_o (ntl_hit)
  );

  hint_fence_class u_fence (
    .w_i         (word),
    .cls_o       (fence_cls),
    .pause_hit_o (pause_hit)
  );

  hint_shamt_guard u_shamt (
    .w_i    (word),
    .rsvd_o (shamt_rsvd)
  );

  assign final_cls    = (fence_cls != HC_NONE) ? fence_cls : alu_cls;
  assign hint_class_o = final_cls;
  assign ntl_sel_o    = (final_cls == HC_NTL) ? alu_sel : '0;
  assign rsvd_enc_o   = shamt_rsvd;

  always_comb begin
    // R1: the two classifiers cover disjoint opcodes
    p_one_source_r1: assert (alu_cls == HC_NONE || fence_cls == HC_NONE)
      else $error("two classifiers claimed one word");
    // R10: a reserved shift encoding is never a hint
    p_rsvd_not_hint_r10: assert (!shamt_rsvd || final_cls == HC_NONE)
      else $error("reserved encoding also classed as hint");
    // R11: level selector quiet outside the non-temporal class
    p_sel_quiet_r11: assert (final_cls == HC_NTL || ntl_sel_o == '0)
      else $error("level selector active outside non-temporal class");
    // R8: pause class only through the fence path
    p_pause_path_r8: assert ((final_cls == HC_PAUSE) == pause_hit)
      else $error("pause class and fence pause disagree");
    // R4: non-temporal class only through the add path
    p_ntl_path_r4: assert ((final_cls == HC_NTL) == ntl_hit)
      else $error("non-temporal class and add path disagree");
  end

endmodule

// File: tb/hint_classifier_tb.sv
`timescale 1ns/1ps
module hint_classifier_tb;

  localparam logic [6:0] O_IMM = 7'h13, O_IMM32 = 7'h1B, O_OP = 7'h33, O_OP32 = 7'h3B;
  localparam logic [6:0] O_LUI = 7'h37, O_AUIPC = 7'h17, O_MISC = 7'h0F;

  function automatic logic [31:0] enc_i(int imm, int rs1, int f3, int rd, logic [6:0] op);
    logic [11:0] i12 = imm[11:0];
    logic [4:0]  a = rs1[4:0];
    logic [2:0]  f = f3[2:0];
    logic [4:0]  d = rd[4:0];
    return {i12, a, f, d, op};
  endfunction

  function automatic logic [31:0] enc_r(int f7, int rs2, int rs1, int f3, int rd, logic [6:0] op);
    logic [6:0] g = f7[6:0];
    logic [4:0] b = rs2[4:0];
    return {g, b, enc_i(0, rs1, f3, rd, op)[19:0]};
  endfunction

  function automatic logic [31:0] enc_u(int imm20, int rd, logic [6:0] op);
    logic [19:0] u = imm20[19:0];
    logic [4:0]  d = rd[4:0];
    return {u, d, op};
  endfunction

  typedef struct packed {
    logic [31:0] w;
    logic [2:0]  c;
    logic [1:0]  s;
    logic        r;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VEC [NV] = '{
    '{enc_i(0, 0, 0, 0, O_IMM),           3'd0, 2'd0, 1'b0, 4'd3},   // R3 no-op
    '{enc_i(0, 1, 0, 0, O_IMM),           3'd1, 2'd0, 1'b0, 4'd3},   // R3 src nonzero
    '{enc_i(5, 0, 0, 0, O_IMM),           3'd1, 2'd0, 1'b0, 4'd3},   // R3 imm nonzero
    '{enc_u(20'h12345, 0, O_LUI),         3'd1, 2'd0, 1'b0, 4'd2},   // R2
    '{enc_u(20'h12345, 5, O_AUIPC),       3'd0, 2'd0, 1'b0, 4'd1},   // R1 rd nonzero
    '{enc_i(12'h7ff, 9, 4, 0, O_IMM),     3'd1, 2'd0, 1'b0, 4'd2},   // R2 xori
    '{enc_i(1, 3, 0, 0, O_IMM32),         3'd1, 2'd0, 1'b0, 4'd2},   // R2 addiw
    '{enc_i(7, 3, 2, 0, O_IMM),           3'd2, 2'd0, 1'b0, 4'd7},   // R7 slti
    '{enc_i(12'h428, 3, 5, 0, O_IMM),     3'd2, 2'd0, 1'b0, 4'd7},   // R7 srai 40
    '{enc_i(12'h403, 3, 5, 0, O_IMM32),   3'd2, 2'd0, 1'b0, 4'd7},   // R7 sraiw
    '{enc_i(12'h021, 3, 1, 0, O_IMM32),   3'd0, 2'd0, 1'b1, 4'd10},  // R10 slliw 33
    '{enc_i(12'h020, 3, 5, 7, O_IMM32),   3'd0, 2'd0, 1'b1, 4'd10},  // R10 rd nonzero
    '{enc_i(12'h420, 3, 5, 0, O_IMM32),   3'd0, 2'd0, 1'b1, 4'd10},  // R10 sraiw
    '{enc_r(0, 3, 0, 0, 0, O_OP),         3'd3, 2'd1, 1'b0, 4'd4},   // R4 level 1
    '{enc_r(0, 5, 0, 0, 0, O_OP),         3'd3, 2'd3, 1'b0, 4'd4},   // R4 level 3
    '{enc_r(0, 3, 1, 0, 0, O_OP),         3'd1, 2'd0, 1'b0, 4'd5},   // R5 rs1 nonzero
    '{enc_r(32, 4, 6, 0, 0, O_OP),        3'd1, 2'd0, 1'b0, 4'd6},   // R6 sub
    '{enc_r(32, 4, 6, 5, 0, O_OP32),      3'd1, 2'd0, 1'b0, 4'd6},   // R6 sraw
    '{enc_r(1, 4, 6, 0, 0, O_OP),         3'd0, 2'd0, 1'b0, 4'd6},   // R6 foreign funct7
    '{enc_r(0, 4, 6, 3, 0, O_OP),         3'd2, 2'd0, 1'b0, 4'd7},   // R7 sltu
    '{enc_i(12'h010, 0, 0, 0, O_MISC),    3'd4, 2'd0, 1'b0, 4'd8},   // R8 pause
    '{enc_i(12'h033, 0, 0, 0, O_MISC),    3'd0, 2'd0, 1'b0, 4'd9},   // R9 both sets
    '{enc_i(12'h003, 0, 0, 0, O_MISC),    3'd1, 2'd0, 1'b0, 4'd9},   // R9 empty pred
    '{enc_i(12'h810, 0, 0, 0, O_MISC),    3'd0, 2'd0, 1'b0, 4'd9},   // R9 fm nonzero
    '{enc_r(0, 4, 6, 6, 4, O_OP),         3'd0, 2'd0, 1'b0, 4'd1}    // R1 or, rd nonzero
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr = 32'd0;
  logic [2:0]  cls;
  logic [1:0]  sel;
  logic        rsv;
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  hint_classifier u_dut (
    .instr_i      (instr),
    .hint_class_o (cls),
    .ntl_sel_o    (sel),
    .rsvd_enc_o   (rsv)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] w);
    @(negedge clk);
    instr = w;
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n_ntl, n_rsvd, n_rsvd0, n_bad, n_cust, n_rsv, n_pause, n_r_a, n_r_b, n_r_c, n_other;
    repeat (3) @(posedge clk);
    #1;
    // R1: all-zero word during reset is not a hint
    chk("R1 reset class", cls, 0);
    chk("R11 reset sel", sel, 0);
    chk("R10 reset flag", rsv, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i].w);
      chk($sformatf("R%0d vec%0d class", VEC[i].req, i), cls, VEC[i].c);
      chk($sformatf("R%0d vec%0d sel", VEC[i].req, i), sel, VEC[i].s);
      chk($sformatf("R%0d vec%0d flag", VEC[i].req, i), rsv, VEC[i].r);
    end

    // R4 R5 R11: register add sweep with x0 destination
    n_ntl = 0; n_rsvd = 0; n_rsvd0 = 0; n_bad = 0;
    for (int a = 0; a < 32; a++) begin
      for (int b = 0; b < 32; b++) begin
        apply(enc_r(0, b, a, 0, 0, O_OP));
        if (cls == 3'd3) begin
          n_ntl++;
          if (a != 0 || b < 2 || b > 5 || sel != 2'(b - 2)) n_bad++;
        end else begin
          if (sel != 2'd0) n_bad++;
          if (cls == 3'd1) begin
            n_rsvd++;
            if (a == 0) n_rsvd0++;
          end
        end
      end
    end
    chk("R4 ntl points", n_ntl, 4);
    chk("R4 R11 selector mismatches", n_bad, 0);
    chk("R5 reserved add points", n_rsvd, 1020);
    chk("R5 reserved add points rs1=x0", n_rsvd0, 28);

    // R7 R10: immediate shifts, source by amount
    n_cust = 0; n_rsv = 0;
    for (int a = 0; a < 32; a++) begin
      for (int s = 0; s < 64; s++) begin
        apply(enc_i(s, a, 1, 0, O_IMM));
        if (cls == 3'd2) n_cust++;
      end
      for (int s = 0; s < 64; s++) begin
        apply(enc_i(s, a, 1, 0, O_IMM32));
        if (cls == 3'd2) n_cust++;
        if (rsv) n_rsv++;
      end
    end
    chk("R7 custom shift points", n_cust, 2048 + 1024);
    chk("R10 reserved word shift points", n_rsv, 1024);

    // R8 R9: fence sweep, fm zero, all pred/succ
    n_pause = 0; n_r_a = 0; n_r_b = 0; n_r_c = 0; n_other = 0;
    for (int a = 0; a < 32; a++) begin
      for (int o = 0; o < 256; o++) begin
        apply(enc_i(o, a, 0, 0, O_MISC));
        if (cls == 3'd4) n_pause++;
        else if (cls == 3'd1) begin
          if (a == 0) n_r_c++; else n_r_a++;
        end
      end
    end
    for (int d = 1; d < 32; d++) begin
      for (int o = 0; o < 256; o++) begin
        apply(enc_i(o, 0, 0, d, O_MISC));
        if (cls == 3'd1) n_r_b++;
        else if (cls != 3'd0) n_other++;
      end
    end
    for (int o = 0; o < 256; o++) begin
      apply(enc_i(o, 9, 0, 5, O_MISC));
      if (cls != 3'd0) n_other++;
    end
    chk("R8 pause points", n_pause, 1);
    chk("R9 reserved rd=x0 rs1!=x0", n_r_a, 961);
    chk("R9 reserved rd!=x0 rs1=x0", n_r_b, 961);
    chk("R9 reserved rd=rs1=x0", n_r_c, 30);
    chk("R9 no hint with both regs nonzero", n_other, 0);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule